// File: doc/BRIEF.md
# Centre-Aligned Complementary PWM Pair

This block drives two gate signals from one triangle timebase. The counter climbs from zero to a programmed period and falls back to zero, so one PWM cycle lasts twice the period in clocks. The output edges sit symmetrically about the counter peak and the counter zero. Each output has a compare threshold. A match while counting up switches the output one way, and a match while counting down switches it back.

Dead time between the two gates can be produced in two ways. In edge-delay mode, gate A's compare waveform is the only source. Its rising edges are held back by one count to make gate A. Its falling edges, after inversion, are held back by a second count to make gate B. The dead time then comes out of the high time of both gates. In compare-offset mode, each gate runs from its own compare value with opposite actions. The dead time is the distance between the two compare values, so neither gate loses high time to a delay stage. Period, compare values, delay counts and mode are all sampled into active copies only while the counter sits at zero or the block is disabled.

Top module: `cpwm_pair_gen`

## Requirements
- R1: The counter runs 0,1,…,P,P−1,…,1,0,1,… so a PWM cycle is 2P clocks. `count_up` is high for the P cycles of the rising ramp, including the peak, and low for the P cycles of the falling ramp, including zero. After enable rises it is high for the first P cycles. A new period applies from the next counter zero.
- R2: With `db_mode`=1 (compare-offset), gate A goes low after an up-count match of `cmp_a` and high after a down-count match, giving a high time of 2·CA and a low time of 2·(P−CA).
- R3: With `db_mode`=1, gate B goes high after an up-count match of `cmp_b` and low after a down-count match, giving a high time of 2·(P−CB). The gap from gate A falling to gate B rising, and from gate B falling to gate A rising, is CB−CA clocks each.
- R4: With `db_mode`=0 (edge-delay), gate A's high time is 2·CA−RD and gate B's high time is 2·(P−CA)−FD. The gap from gate A falling to gate B rising is FD, and the gap from gate B falling to gate A rising is RD.
- R5: A delay count of 0 passes its edge unchanged. In edge-delay mode with RD=FD=0, gate B is the exact complement of gate A, with no gaps.
- R6: A compare value of 0 holds its gate at a constant level, and so does a compare value at or above P. In compare-offset mode, gate A is low for 0 and high for ≥P, and gate B is high for 0 and low for ≥P.
- R7: Writes to the compare values, the delays, the mode or the period take effect only at the next counter zero. A write in mid-cycle does not alter the edges still due in the current cycle.
- R8: While `en` is low the counter is held at zero, `count_up` is high, and both gates are low from the next clock onward.
- R9: In edge-delay mode the two gates are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the counter at zero and the gates low |
| db_mode | input | 1 | 0 = edge-delay dead band, 1 = compare-offset dead band |
| period | input | CNT_W | Peak count P of the triangle |
| cmp_a | input | CNT_W | Compare threshold for gate A |
| cmp_b | input | CNT_W | Compare threshold for gate B (compare-offset mode) |
| rise_dly | input | DLY_W | Delay in clocks applied to gate A's rising edge (edge-delay mode) |
| fall_dly | input | DLY_W | Delay in clocks applied to gate B's rising edge, which follows gate A's fall (edge-delay mode) |
| gate_a | output | 1 | Gate A |
| gate_b | output | 1 | Gate B |
| count_up | output | 1 | Counter direction, high while counting up |

## Verification
The bench measures the high time of each gate and both dead gaps over whole cycles. It uses asymmetric rise and fall delays, so a design that swapped the two delays, or delayed the wrong edge, gives the wrong pair of gaps. A compare write made just after gate A falls must leave that low interval at its old length. A design that reloads compares at once would shorten it. The mixed old/new high time that follows checks that the reload happens exactly at zero. Compare values of zero and of the period are checked for constant gates, since a design without the forcing would still switch or stick at the wrong level. A run with both delays at zero checks for a delay stage that adds a cycle.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;

    // Dead-band source select; encoding matches the db_mode port.
    typedef enum logic {
        DB_EDGE_DELAY = 1'b0,
        DB_CMP_OFFSET = 1'b1
    } db_mode_e;

    // One sample of the two gate lines.
    typedef struct packed {
        logic a;
        logic b;
    } gate_pair_t;

    // Choose the gate pair for the active dead-band mode.
    function automatic gate_pair_t pick_pair(db_mode_e m, gate_pair_t offs, gate_pair_t dly);
        return (m == DB_CMP_OFFSET) ? offs : dly;
    endfunction

endpackage

// File: rtl/cpwm_timebase.sv
`timescale 1ns/1ps
module cpwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] per_sh,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_q,
    output logic             dir_up,
    output logic             reload
);

    logic at_zero;
    logic [CNT_W-1:0] lim;

    assign at_zero = (cnt == '0);
    assign reload  = !en || at_zero;
    // At zero the incoming period already governs the next ramp.
    assign lim     = at_zero ? per_sh : per_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt    <= '0;
            dir_up <= 1'b1;
            per_q  <= per_sh;
        end else begin
            if (at_zero) per_q <= per_sh;
            if (lim == '0) begin
                cnt    <= '0;
                dir_up <= 1'b1;
            end else if (at_zero) begin
                cnt    <= CNT_W'(1);
                dir_up <= 1'b1;
            end else if (dir_up && cnt >= lim) begin
                cnt    <= cnt - 1'b1;
                dir_up <= 1'b0;
            end else if (dir_up) begin
                cnt    <= cnt + 1'b1;
            end else begin
                cnt    <= cnt - 1'b1;
            end
        end
    end

    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> cnt <= per_q);

    // R1
    peak_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (en && dir_up && cnt == per_q && cnt != '0) |=> (!dir_up || cnt == '0));

endmodule

// File: rtl/cpwm_action.sv
`timescale 1ns/1ps
module cpwm_action #(
    parameter int CNT_W = 16,
    parameter bit INV   = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic             dir_up,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] cmp,
    output logic             o
);

    // lvl is the non-inverted waveform: high around zero, low around the peak.
    logic lvl;
    logic lo_force;
    logic hi_force;

    assign lo_force = (cmp == '0);
    assign hi_force = (cmp >= per);

    always_comb begin
        if (lo_force)          lvl = 1'b0;
        else if (hi_force)     lvl = 1'b1;
        else if (cnt == '0)    lvl = 1'b1;
        else if (cnt == cmp)   lvl = !dir_up;
        else                   lvl = o ^ INV;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) o <= 1'b0;
        else            o <= lvl ^ INV;
    end

    // R6
    cmp_zero_level_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cmp == '0) |=> (o == INV));

    // R6
    cmp_top_level_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cmp != '0 && cmp >= per) |=> (o != INV));

endmodule

// File: rtl/cpwm_edge_delay.sv
`timescale 1ns/1ps
module cpwm_edge_delay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             x,
    input  logic [DLY_W-1:0] dly,
    output logic             y
);

    // Number of cycles x has already been high before this one (saturating).
    logic [DLY_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst || !en || !x) run <= '0;
        else if (run != '1)   run <= run + 1'b1;
    end

    assign y = x && (run >= dly);

    // R4
    delayed_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (en && dly != '0 && $rose(y)) |-> $past(x));

endmodule

// File: rtl/cpwm_pair_gen.sv
`timescale 1ns/1ps
module cpwm_pair_gen
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             db_mode,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    output logic             gate_a,
    output logic             gate_b,
    output logic             count_up
);

    localparam int NCH = 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_q;
    logic             dir_up;
    logic             reload;

    logic [CNT_W-1:0] cmp_q [NCH];
    logic [DLY_W-1:0] red_q;
    logic [DLY_W-1:0] fed_q;
    db_mode_e         mode_q;
    db_mode_e         mode_d;

    logic [NCH-1:0]   act;
    logic             dly_a;
    logic             dly_b;
    gate_pair_t       nxt;
    gate_pair_t       gq;

    cpwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .per_sh (period),
        .cnt    (cnt),
        .per_q  (per_q),
        .dir_up (dir_up),
        .reload (reload)
    );

    // Active copies follow the inputs only at counter zero or while idle.
    always_ff @(posedge clk) begin
        if (rst || reload) begin
            cmp_q[0] <= cmp_a;
            cmp_q[1] <= cmp_b;
            red_q    <= rise_dly;
            fed_q    <= fall_dly;
            mode_q   <= db_mode_e'(db_mode);
        end
    end

    // Channel 0 clears on up-match; channel 1 runs the reversed actions.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        cpwm_action #(.CNT_W(CNT_W), .INV(ch == 1)) u_act (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .cnt    (cnt),
            .dir_up (dir_up),
            .per    (per_q),
            .cmp    (cmp_q[ch]),
            .o      (act[ch])
        );
    end

    cpwm_edge_delay #(.DLY_W(DLY_W)) u_dly_rise (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .x   (act[0]),
        .dly (red_q),
        .y   (dly_a)
    );

    cpwm_edge_delay #(.DLY_W(DLY_W)) u_dly_fall (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .x   (!act[0]),
        .dly (fed_q),
        .y   (dly_b)
    );

    assign nxt = pick_pair(mode_q, '{a: act[0], b: act[1]}, '{a: dly_a, b: dly_b});

    always_ff @(posedge clk) begin
        if (rst || !en) gq <= '0;
        else            gq <= nxt;
        mode_d <= mode_q;
    end

    assign gate_a   = gq.a;
    assign gate_b   = gq.b;
    assign count_up = dir_up;

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!gate_a && !gate_b));

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_d == DB_EDGE_DELAY) |-> !(gate_a && gate_b));

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt != '0) |=> ($stable(cmp_q[0]) && $stable(cmp_q[1]) && $stable(mode_q)));

endmodule

// File: tb/tb_cpwm_pair_gen.sv
`timescale 1ns/1ps
module tb_cpwm_pair_gen;

    localparam int CNT_W = 16;
    localparam int DLY_W = 8;

    typedef struct packed {
        int hi_a;
        int gap_ab;
        int hi_b;
        int gap_ba;
    } shape_t;

    logic             clk = 1'b0;
    logic             rst;
    logic             en;
    logic             db_mode;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] cmp_a;
    logic [CNT_W-1:0] cmp_b;
    logic [DLY_W-1:0] rise_dly;
    logic [DLY_W-1:0] fall_dly;
    logic             gate_a;
    logic             gate_b;
    logic             count_up;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    shape_t exp_q[$];
    string  tag_q[$];

    always #2.5 clk = ~clk;

    cpwm_pair_gen #(.CNT_W(CNT_W), .DLY_W(DLY_W)) dut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .db_mode  (db_mode),
        .period   (period),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .rise_dly (rise_dly),
        .fall_dly (fall_dly),
        .gate_a   (gate_a),
        .gate_b   (gate_b),
        .count_up (count_up)
    );

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Driver side of the scoreboard: queue one expected cycle shape and wait for it.
    task automatic expect_shape(string tag, int ha, int g1, int hb, int g2);
        shape_t s;
        int target;
        s.hi_a = ha; s.gap_ab = g1; s.hi_b = hb; s.gap_ba = g2;
        target = done_cnt + 1;
        tag_q.push_back(tag);
        exp_q.push_back(s);
        wait (done_cnt == target);
    endtask

    task automatic configure(logic m, int p, int ca, int cb, int rd, int fd);
        @(negedge clk);
        db_mode  = m;
        period   = CNT_W'(p);
        cmp_a    = CNT_W'(ca);
        cmp_b    = CNT_W'(cb);
        rise_dly = DLY_W'(rd);
        fall_dly = DLY_W'(fd);
        repeat (250) @(negedge clk);
    endtask

    // Monitor side: measure one whole cycle starting at a rise of gate A.
    initial begin : monitor
        shape_t cur;
        string  tag;
        int n_ha, n_g1, n_hb, n_g2;
        forever begin
            wait (exp_q.size() > 0);
            cur = exp_q.pop_front();
            tag = tag_q.pop_front();
            @(negedge clk);
            while (gate_a !== 1'b0) @(negedge clk);
            while (gate_a !== 1'b1) @(negedge clk);
            n_ha = 0; n_g1 = 0; n_hb = 0; n_g2 = 0;
            while (gate_a === 1'b1) begin n_ha++; @(negedge clk); end
            while (gate_a === 1'b0 && gate_b === 1'b0) begin n_g1++; @(negedge clk); end
            while (gate_b === 1'b1) begin n_hb++; @(negedge clk); end
            while (gate_a === 1'b0 && gate_b === 1'b0) begin n_g2++; @(negedge clk); end
            check({tag, " gate A high time"}, n_ha, cur.hi_a);
            check({tag, " gap A-fall to B-rise"}, n_g1, cur.gap_ab);
            check({tag, " gate B high time"}, n_hb, cur.hi_b);
            check({tag, " gap B-fall to A-rise"}, n_g2, cur.gap_ba);
            check({tag, " R1 cycle length"}, n_ha + n_g1 + n_hb + n_g2,
                  cur.hi_a + cur.gap_ab + cur.hi_b + cur.gap_ba);
            done_cnt++;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin : main
        int n;
        rst = 1'b1; en = 1'b0; db_mode = 1'b1;
        period = 16'd50; cmp_a = 16'd20; cmp_b = 16'd30;
        rise_dly = '0; fall_dly = '0;
        repeat (5) @(negedge clk);
        check("R8 reset gate A", int'(gate_a), 0);
        check("R8 reset gate B", int'(gate_b), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R8 idle count_up", int'(count_up), 1);
        check("R8 idle gates", int'(gate_a | gate_b), 0);

        // R1: first up-ramp after enable lasts P cycles
        en = 1'b1;
        n = 0;
        repeat (50) begin @(negedge clk); if (count_up) n++; end
        check("R1 first up-ramp length", n, 50);
        @(negedge clk);
        check("R1 turn at peak", int'(count_up), 0);

        // R2 / R3: compare-offset mode, P=50 CA=20 CB=30
        configure(1'b1, 50, 20, 30, 0, 0);
        expect_shape("R2 R3 offset", 40, 10, 40, 10);

        // R1: steady ramp lengths
        while (count_up !== 1'b1) @(negedge clk);
        while (count_up !== 1'b0) @(negedge clk);
        n = 0;
        while (count_up === 1'b0) begin n++; @(negedge clk); end
        check("R1 down-ramp length", n, 50);
        n = 0;
        while (count_up === 1'b1) begin n++; @(negedge clk); end
        check("R1 up-ramp length", n, 50);

        // R7: write new compares right after gate A falls
        while (gate_a !== 1'b1) @(negedge clk);
        while (gate_a !== 1'b0) @(negedge clk);
        cmp_a = 16'd35; cmp_b = 16'd40;
        n = 0;
        while (gate_a === 1'b0) begin n++; @(negedge clk); end
        check("R7 low time keeps old compare", n, 60);
        n = 0;
        while (gate_a === 1'b1) begin n++; @(negedge clk); end
        check("R7 high time old+new compare", n, 55);

        // R4: edge-delay mode, symmetric delays
        configure(1'b0, 50, 25, 0, 5, 5);
        expect_shape("R4 equal delays", 45, 5, 45, 5);

        // R4: unequal delays
        configure(1'b0, 50, 20, 0, 3, 7);
        expect_shape("R4 unequal delays", 37, 7, 53, 3);

        // R9: never both high in edge-delay mode
        n = 0;
        repeat (300) begin @(negedge clk); if (gate_a && gate_b) n++; end
        check("R9 overlap cycles", n, 0);

        // R5: zero delays pass through
        configure(1'b0, 50, 30, 0, 0, 0);
        expect_shape("R5 zero delay", 60, 0, 40, 0);

        // R1: period change, offset mode P=40 CA=10 CB=14
        configure(1'b1, 40, 10, 14, 0, 0);
        expect_shape("R1 R3 new period", 20, 4, 52, 4);

        // R6: compare extremes
        configure(1'b1, 50, 0, 0, 0, 0);
        n = 0;
        repeat (100) begin @(negedge clk); if (gate_a !== 1'b0 || gate_b !== 1'b1) n++; end
        check("R6 compare zero levels", n, 0);
        configure(1'b1, 50, 50, 60, 0, 0);
        n = 0;
        repeat (100) begin @(negedge clk); if (gate_a !== 1'b1 || gate_b !== 1'b0) n++; end
        check("R6 compare at/above period levels", n, 0);

        // R8: disable while running
        configure(1'b1, 50, 20, 30, 0, 0);
        while (gate_a !== 1'b1) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R8 gates low after disable", int'(gate_a | gate_b), 0);
        check("R8 count_up after disable", int'(count_up), 1);

        report();
    end

endmodule